// File: doc/BRIEF.md
# DRAM Read Command Spacing Checker

This block sits beside a DDR3-style memory controller and watches the command stream it sends. Each clock it states which commands may legally go out next. One global flag permits a WRITE. One flag per bank permits a PRECHARGE. One flag per bank permits any other command (ACTIVATE, READ, READ with auto precharge, WRITE) to that bank. A scheduler can gate its choices with these flags. The block can also run as a passive monitor, since any illegal command that does get through is still accepted and is recorded in a sticky violation flag together with its command code.

The READ-to-WRITE gap is derived from the read latency, the write latency and the column-to-column delay. The READ-to-PRECHARGE gap for a bank is the later of a four-clock floor and a window of tRTP that opens additive-latency clocks after the READ. After a PRECHARGE, the bank is blocked for tRP clocks. A further PRECHARGE stays legal during that time and restarts the window. A READ with auto precharge starts an internal precharge when the READ-to-PRECHARGE gap expires. Until then the bank is locked, and the tRP window follows from that point. The six timing values are static inputs and are captured only while reset is held.

Top module: `rdg_guard`

## Requirements
- R1: The first cycle after reset is released shows `wr_ok` high, every bit of `pre_ok` and `bank_ok` high, `viol` low and `viol_code` equal to 0.
- R2: Command codes are 3 bits: NOP=0, ACT=1, RD=2, RDA=3, WR=4, PRE=5. Codes 6 and 7 are treated as NOP: they change no timing state and never set `viol`.
- R3: A READ (RD or RDA) to any bank lowers `wr_ok` for the following cycles until RL + tCCD − WL + 2 cycles have passed since the READ. If that span is 1 or less, `wr_ok` does not drop.
- R4: A READ to bank b holds `pre_ok[b]` low until max(4, AL + tRTP) cycles have passed since the READ.
- R5: A PRE to bank b holds `bank_ok[b]` low for tRP cycles and leaves `pre_ok[b]` high. A second PRE during that time is legal and restarts the tRP window from itself.
- R6: An RDA to bank b issued in cycle t holds `pre_ok[b]` and `bank_ok[b]` low through cycle t + L, where L = max(4, AL + tRTP). An internal precharge starts in that cycle, so `pre_ok[b]` rises at t + L + 1 and `bank_ok[b]` rises at t + L + tRP.
- R7: A command is illegal when it is one of the following: ACT, RD or RDA with `bank_ok` low for its bank; WR with `wr_ok` or the bank's `bank_ok` low; PRE with the bank's `pre_ok` low. An illegal command raises `viol` in the next cycle. It loads its code into `viol_code` only if `viol` was clear. The command still updates the timing state as if it were legal.
- R8: `viol` stays high until `clr_viol` is asserted. A clear with no illegal command returns `viol` and `viol_code` to 0 in the next cycle. An illegal command in the same cycle as a clear wins and records its own code.
- R9: The six timing inputs are captured only while `rst` is high. Changing them afterwards does not alter any window.
- R10: Banks are independent: a READ or PRE to one bank leaves the `pre_ok` and `bank_ok` flags of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; timing inputs are captured while high |
| clr_viol | input | 1 | Synchronous clear of the sticky violation record |
| cfg_rl | input | CFG_W | Read latency in clocks |
| cfg_wl | input | CFG_W | Write latency in clocks |
| cfg_al | input | CFG_W | Additive latency in clocks |
| cfg_ccd | input | CFG_W | Column-to-column delay in clocks |
| cfg_rtp | input | CFG_W | Read-to-precharge time in clocks |
| cfg_rp | input | CFG_W | Precharge period in clocks |
| cmd_vld | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Command code (see R2) |
| cmd_bank | input | BANK_W | Target bank |
| wr_ok | output | 1 | A WRITE is permitted by the read-to-write gap |
| pre_ok | output | NUM_BANKS | Per bank: a PRECHARGE is permitted |
| bank_ok | output | NUM_BANKS | Per bank: a non-precharge command is permitted |
| viol | output | 1 | Sticky: an illegal command was seen |
| viol_code | output | 3 | Code of the first illegal command since the last clear |

## Verification
The bench aims at the cycle where each window opens. It measures the exact rise of `wr_ok` and `pre_ok` after a READ, and it does so under a configuration where AL + tRTP exceeds four and under one where the four-clock floor dominates. An off-by-one counter load would show up there as a permit one cycle early or late, and a missing floor would open the precharge window after two cycles instead of four. A double PRECHARGE checks that tRP restarts, so a design that kept the first window would release the bank three cycles too early. An auto-precharge READ checks that the bank stays locked until the internal precharge and its tRP are over. A design that never started the internal precharge would never lock the bank afterwards, and one that forgot the lock would permit an early PRECHARGE. Further cases cover the retention of the first violation code, the win of a set over a simultaneous clear, codes 6 and 7 being ignored, and timing inputs changed after reset.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

  // Command encoding seen on cmd_code.
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_WR  = 3'd4,
    CMD_PRE = 3'd5
  } cmd_e;

  // Minimum READ-to-PRECHARGE spacing in clocks.
  localparam int RD2PRE_FLOOR = 4;

  function automatic logic code_is_read(input logic [2:0] code);
    return (code == CMD_RD) || (code == CMD_RDA);
  endfunction

endpackage

// File: rtl/rdg_cfg.sv
// Captures the timing inputs during reset and derives the counter load values.
module rdg_cfg import rdg_pkg::*; #(
  parameter int CFG_W = 6,
  parameter int CNT_W = CFG_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_rl,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_ccd,
  input  logic [CFG_W-1:0] cfg_rtp,
  input  logic [CFG_W-1:0] cfg_rp,
  output logic [CNT_W-1:0] rw_load,
  output logic [CNT_W-1:0] pre_load,
  output logic [CNT_W-1:0] rp_load
);

  logic [CFG_W-1:0] rl_q, wl_q, al_q, ccd_q, rtp_q, rp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rl_q  <= cfg_rl;
      wl_q  <= cfg_wl;
      al_q  <= cfg_al;
      ccd_q <= cfg_ccd;
      rtp_q <= cfg_rtp;
      rp_q  <= cfg_rp;
    end
  end

  int rw_span;
  int pre_span;

  // Loads are span-1: the counter is first seen in the cycle after the command.
  always_comb begin
    rw_span  = int'(rl_q) + int'(ccd_q) + 2 - int'(wl_q);
    pre_span = int'(al_q) + int'(rtp_q);
    if (pre_span < RD2PRE_FLOOR) pre_span = RD2PRE_FLOOR;
    rw_load  = (rw_span > 1) ? CNT_W'(rw_span - 1) : '0;
    pre_load = CNT_W'(pre_span - 1);
    rp_load  = (rp_q != '0) ? CNT_W'(int'(rp_q) - 1) : '0;
  end

endmodule

// File: rtl/rdg_down_cnt.sv
// Loadable down-counter with a registered "reached zero" flag.
module rdg_down_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      zero  <= 1'b1;
    end else if (load) begin
      cnt_q <= load_val;
      zero  <= (load_val == '0);
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
      zero <= (cnt_q <= W'(1));
    end
  end

endmodule

// File: rtl/rdg_bank.sv
// Per-bank timing: read-to-precharge gap, precharge period, auto-precharge lock.
module rdg_bank #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  logic             rda_hit,
  input  logic             pre_hit,
  input  logic [CNT_W-1:0] pre_load,
  input  logic [CNT_W-1:0] rp_load,
  output logic             pre_ok,
  output logic             bank_ok
);

  logic rtp_zero;
  logic rp_zero;
  logic ap_q;
  logic ap_fire;

  // Internal precharge begins in the cycle the read-to-precharge gap expires.
  assign ap_fire = ap_q && rtp_zero;

  rdg_down_cnt #(.W(CNT_W)) u_rtp_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (rd_hit),
    .load_val (pre_load),
    .zero     (rtp_zero)
  );

  rdg_down_cnt #(.W(CNT_W)) u_rp_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (pre_hit || ap_fire),
    .load_val (rp_load),
    .zero     (rp_zero)
  );

  always_ff @(posedge clk) begin
    if (rst)          ap_q <= 1'b0;
    else if (pre_hit) ap_q <= 1'b0;
    else if (rda_hit) ap_q <= 1'b1;
    else if (ap_fire) ap_q <= 1'b0;
  end

  assign pre_ok  = rtp_zero && !ap_q;
  assign bank_ok = rp_zero && !ap_q;

endmodule

// File: rtl/rdg_judge.sv
// Decides legality of the current command and keeps the sticky record.
module rdg_judge import rdg_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_viol,
  input  logic       cmd_vld,
  input  logic [2:0] cmd_code,
  input  logic       wr_ok,
  input  logic       pre_ok_sel,
  input  logic       bank_ok_sel,
  output logic       viol,
  output logic [2:0] viol_code
);

  logic bad;

  always_comb begin
    bad = 1'b0;
    if (cmd_vld) begin
      case (cmd_code)
        CMD_ACT, CMD_RD, CMD_RDA: bad = !bank_ok_sel;
        CMD_WR:                   bad = !(wr_ok && bank_ok_sel);
        CMD_PRE:                  bad = !pre_ok_sel;
        default:                  bad = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= 1'b0;
      viol_code <= 3'd0;
    end else if (bad) begin
      viol <= 1'b1;
      if (!viol || clr_viol) viol_code <= cmd_code;
    end else if (clr_viol) begin
      viol      <= 1'b0;
      viol_code <= 3'd0;
    end
  end

endmodule

// File: rtl/rdg_guard.sv
module rdg_guard import rdg_pkg::*; #(
  parameter int NUM_BANKS = 8,
  parameter int CFG_W     = 6,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr_viol,
  input  logic [CFG_W-1:0]     cfg_rl,
  input  logic [CFG_W-1:0]     cfg_wl,
  input  logic [CFG_W-1:0]     cfg_al,
  input  logic [CFG_W-1:0]     cfg_ccd,
  input  logic [CFG_W-1:0]     cfg_rtp,
  input  logic [CFG_W-1:0]     cfg_rp,
  input  logic                 cmd_vld,
  input  logic [2:0]           cmd_code,
  input  logic [BANK_W-1:0]    cmd_bank,
  output logic                 wr_ok,
  output logic [NUM_BANKS-1:0] pre_ok,
  output logic [NUM_BANKS-1:0] bank_ok,
  output logic                 viol,
  output logic [2:0]           viol_code
);

  localparam int CNT_W = CFG_W + 2;

  logic [CNT_W-1:0] rw_load, pre_load, rp_load;
  logic             any_rd, is_rda, is_pre;

  assign any_rd = cmd_vld && code_is_read(cmd_code);
  assign is_rda = cmd_vld && (cmd_code == CMD_RDA);
  assign is_pre = cmd_vld && (cmd_code == CMD_PRE);

  rdg_cfg #(.CFG_W(CFG_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .cfg_rl   (cfg_rl),
    .cfg_wl   (cfg_wl),
    .cfg_al   (cfg_al),
    .cfg_ccd  (cfg_ccd),
    .cfg_rtp  (cfg_rtp),
    .cfg_rp   (cfg_rp),
    .rw_load  (rw_load),
    .pre_load (pre_load),
    .rp_load  (rp_load)
  );

  // Read-to-write gap applies across all banks.
  rdg_down_cnt #(.W(CNT_W)) u_wr_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (any_rd),
    .load_val (rw_load),
    .zero     (wr_ok)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_W'(g));

    rdg_bank #(.CNT_W(CNT_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .rd_hit   (any_rd && hit),
      .rda_hit  (is_rda && hit),
      .pre_hit  (is_pre && hit),
      .pre_load (pre_load),
      .rp_load  (rp_load),
      .pre_ok   (pre_ok[g]),
      .bank_ok  (bank_ok[g])
    );
  end

  rdg_judge u_judge (
    .clk         (clk),
    .rst         (rst),
    .clr_viol    (clr_viol),
    .cmd_vld     (cmd_vld),
    .cmd_code    (cmd_code),
    .wr_ok       (wr_ok),
    .pre_ok_sel  (pre_ok[cmd_bank]),
    .bank_ok_sel (bank_ok[cmd_bank]),
    .viol        (viol),
    .viol_code   (viol_code)
  );

endmodule

// File: rtl/rdg_guard_chk.sv
module rdg_guard_chk #(
  parameter int NUM_BANKS = 8,
  parameter int CFG_W     = 6,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clr_viol,
  input logic [CFG_W-1:0]     cfg_rl,
  input logic [CFG_W-1:0]     cfg_wl,
  input logic [CFG_W-1:0]     cfg_ccd,
  input logic [CFG_W-1:0]     cfg_rp,
  input logic                 cmd_vld,
  input logic [2:0]           cmd_code,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 wr_ok,
  input logic [NUM_BANKS-1:0] pre_ok,
  input logic [NUM_BANKS-1:0] bank_ok,
  input logic                 viol,
  input logic [2:0]           viol_code
);

  int rw_span_c;
  int rp_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      rw_span_c <= int'(cfg_rl) + int'(cfg_ccd) + 2 - int'(cfg_wl);
      rp_c      <= int'(cfg_rp);
    end
  end

  logic is_read_c;
  assign is_read_c = cmd_vld && (cmd_code == 3'd2 || cmd_code == 3'd3);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (wr_ok && (&pre_ok) && (&bank_ok) && !viol && viol_code == 3'd0));

  p_ignored_code_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code > 3'd5 && !clr_viol) |=> $stable(viol));

  p_wr_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (is_read_c && rw_span_c > 1) |=> !wr_ok);

  p_pre_gap_r4: assert property (@(posedge clk) disable iff (rst)
    is_read_c |=> !pre_ok[$past(cmd_bank)]);

  p_repre_ok_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code == 3'd5 && pre_ok[cmd_bank]) |=> pre_ok[$past(cmd_bank)]);

  p_rp_block_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code == 3'd5 && rp_c > 1) |=> !bank_ok[$past(cmd_bank)]);

  p_rda_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_vld && cmd_code == 3'd3) |=> !bank_ok[$past(cmd_bank)]);

  p_viol_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (viol && !clr_viol) |=> viol);

  p_viol_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_viol && !cmd_vld) |=> (!viol && viol_code == 3'd0));

endmodule

bind rdg_guard rdg_guard_chk #(
  .NUM_BANKS (NUM_BANKS),
  .CFG_W     (CFG_W),
  .BANK_W    (BANK_W)
) u_rdg_guard_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_viol  (clr_viol),
  .cfg_rl    (cfg_rl),
  .cfg_wl    (cfg_wl),
  .cfg_ccd   (cfg_ccd),
  .cfg_rp    (cfg_rp),
  .cmd_vld   (cmd_vld),
  .cmd_code  (cmd_code),
  .cmd_bank  (cmd_bank),
  .wr_ok     (wr_ok),
  .pre_ok    (pre_ok),
  .bank_ok   (bank_ok),
  .viol      (viol),
  .viol_code (viol_code)
);

// File: tb/rdg_guard_bench.sv
`timescale 1ns/1ps
module rdg_guard_bench;

  localparam int NB = 8;
  localparam int CW = 6;
  localparam int BW = 3;
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_RDA = 3'd3,
                         C_WR = 3'd4, C_PRE = 3'd5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst = 1'b1, clr_viol = 1'b0, cmd_vld = 1'b0;
  logic [CW-1:0] cfg_rl = '0, cfg_wl = '0, cfg_al = '0, cfg_ccd = '0, cfg_rtp = '0, cfg_rp = '0;
  logic [2:0]    cmd_code = 3'd0;
  logic [BW-1:0] cmd_bank = '0;
  logic          wr_ok, viol;
  logic [NB-1:0] pre_ok, bank_ok;
  logic [2:0]    viol_code;

  rdg_guard #(.NUM_BANKS(NB), .CFG_W(CW)) u_rdg_guard (
    .clk(clk), .rst(rst), .clr_viol(clr_viol),
    .cfg_rl(cfg_rl), .cfg_wl(cfg_wl), .cfg_al(cfg_al), .cfg_ccd(cfg_ccd),
    .cfg_rtp(cfg_rtp), .cfg_rp(cfg_rp),
    .cmd_vld(cmd_vld), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .wr_ok(wr_ok), .pre_ok(pre_ok), .bank_ok(bank_ok),
    .viol(viol), .viol_code(viol_code)
  );

  int total = 0, fails = 0, cyc = 0;

  // Reference model: timestamps of events, windows from the requirements.
  int  m_rw, m_l, m_rp;
  int  rd_t[NB], pre_t[NB], rdg_t;
  bit  has_rd[NB], has_pre[NB], ap[NB], has_rdg;
  bit  e_viol;
  logic [2:0] e_code;

  logic          s_wr, s_viol;
  logic [NB-1:0] s_pre, s_bank;
  logic [2:0]    s_code;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit x_wr();
    return !(has_rdg && (cyc - rdg_t) < m_rw);
  endfunction
  function automatic bit x_pre(input int b);
    return !(has_rd[b] && (cyc - rd_t[b]) < m_l) && !ap[b];
  endfunction
  function automatic bit x_bank(input int b);
    return !ap[b] && !(has_pre[b] && (cyc - pre_t[b]) < m_rp);
  endfunction
  function automatic bit x_legal(input logic [2:0] c, input int b);
    case (c)
      C_ACT, C_RD, C_RDA: return x_bank(b);
      C_WR:               return x_wr() && x_bank(b);
      C_PRE:              return x_pre(b);
      default:            return 1'b1;
    endcase
  endfunction

  task automatic model_clear();
    for (int b = 0; b < NB; b++) begin
      has_rd[b] = 0; has_pre[b] = 0; ap[b] = 0; rd_t[b] = 0; pre_t[b] = 0;
    end
    has_rdg = 0; rdg_t = 0; e_viol = 0; e_code = 3'd0;
  endtask

  task automatic do_reset(input int rl, input int wl, input int al, input int ccd, input int rtp, input int rp);
    cfg_rl = CW'(rl); cfg_wl = CW'(wl); cfg_al = CW'(al);
    cfg_ccd = CW'(ccd); cfg_rtp = CW'(rtp); cfg_rp = CW'(rp);
    m_rw = rl + ccd - wl + 2;
    m_l  = (al + rtp < 4) ? 4 : al + rtp;
    m_rp = rp;
    rst = 1'b1; cmd_vld = 1'b0; clr_viol = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
    // R1: reset state visible right after release
    chk(wr_ok === 1'b1, "R1", "wr_ok", int'(wr_ok), 1);
    chk(pre_ok === '1, "R1", "pre_ok", int'(pre_ok), int'({NB{1'b1}}));
    chk(bank_ok === '1, "R1", "bank_ok", int'(bank_ok), int'({NB{1'b1}}));
    chk(viol === 1'b0 && viol_code === 3'd0, "R1", "viol/code", int'({viol, viol_code}), 0);
  endtask

  // One cycle: compare outputs for this cycle, drive a command, advance the model.
  task automatic step(input bit v, input logic [2:0] c, input int b, input bit clr);
    logic [NB-1:0] ep, eb;
    bit bad;
    @(negedge clk);
    s_wr = wr_ok; s_pre = pre_ok; s_bank = bank_ok; s_viol = viol; s_code = viol_code;
    for (int i = 0; i < NB; i++) begin
      ep[i] = x_pre(i);
      eb[i] = x_bank(i);
    end
    chk(s_wr === x_wr(), "R3", "wr_ok", int'(s_wr), int'(x_wr()));
    chk(s_pre === ep, "R4,R6,R10", "pre_ok", int'(s_pre), int'(ep));
    chk(s_bank === eb, "R5,R6,R10", "bank_ok", int'(s_bank), int'(eb));
    chk(s_viol === e_viol && s_code === e_code, "R7,R8", "viol/code",
        int'({s_viol, s_code}), int'({e_viol, e_code}));
    bad = v && !x_legal(c, b);
    cmd_vld = v; cmd_code = c; cmd_bank = BW'(b); clr_viol = clr;
    for (int i = 0; i < NB; i++)
      if (ap[i] && cyc >= rd_t[i] + m_l) begin
        ap[i] = 0; has_pre[i] = 1; pre_t[i] = cyc;
      end
    if (v) begin
      if (c == C_PRE) begin
        has_pre[b] = 1; pre_t[b] = cyc; ap[b] = 0;
      end else if (c == C_RD || c == C_RDA) begin
        has_rd[b] = 1; rd_t[b] = cyc; has_rdg = 1; rdg_t = cyc;
        if (c == C_RDA) ap[b] = 1;
      end
    end
    if (bad) begin
      if (!e_viol || clr) e_code = c;
      e_viol = 1;
    end else if (clr) begin
      e_viol = 0; e_code = 3'd0;
    end
    @(posedge clk);
    #1;
    cmd_vld = 1'b0; clr_viol = 1'b0;
    cyc++;
  endtask

  task automatic idle();
    step(0, C_NOP, 0, 0);
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [2:0] c;
      int b;
      bit clr;
      c = 3'($urandom % 8);
      b = int'($urandom % NB);
      clr = ($urandom % 40) == 0;
      if (($urandom % 100) < 88 && !x_legal(c, b)) c = C_NOP;
      step(1, c, b, clr);
    end
  endtask

  int k_wr, k_pre, k_bank;
  bit other_ok;

  initial begin
    #(5.0 * 100000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Config A: RL6 WL5 AL2 CCD4 RTP4 RP6 -> write gap 7, read-to-pre 6
    do_reset(6, 5, 2, 4, 4, 6);

    // R3, R4, R10: gaps after a READ to bank 1
    step(1, C_RD, 1, 0);
    k_wr = 0; k_pre = 0; other_ok = 1;
    for (int k = 1; k <= 20; k++) begin
      idle();
      if (s_wr && k_wr == 0) k_wr = k;
      if (s_pre[1] && k_pre == 0) k_pre = k;
      if (!s_pre[5] || !s_bank[5]) other_ok = 0;
    end
    chk(k_wr == 7, "R3", "write gap", k_wr, 7);
    chk(k_pre == 6, "R4", "read-to-pre gap", k_pre, 6);
    chk(other_ok, "R10", "bank 5 untouched", int'(other_ok), 1);

    // R5: second PRE during tRP is legal and restarts the window
    step(1, C_PRE, 1, 0);
    idle(); idle();
    step(1, C_PRE, 1, 0);
    chk(s_pre[1] == 1'b1, "R5", "pre_ok during tRP", int'(s_pre[1]), 1);
    chk(s_bank[1] == 1'b0, "R5", "bank_ok during tRP", int'(s_bank[1]), 0);
    k_bank = 0;
    for (int k = 1; k <= 20; k++) begin
      idle();
      if (s_bank[1] && k_bank == 0) k_bank = k;
    end
    chk(k_bank == 6, "R5", "tRP restart", k_bank, 6);
    chk(s_viol == 1'b0, "R5", "double PRE flagged", int'(s_viol), 0);

    // R6: READ with auto precharge on bank 3
    step(1, C_RDA, 3, 0);
    k_pre = 0; k_bank = 0;
    for (int k = 1; k <= 25; k++) begin
      idle();
      if (s_pre[3] && k_pre == 0) k_pre = k;
      if (s_bank[3] && k_bank == 0) k_bank = k;
    end
    chk(k_pre == 7, "R6", "pre_ok after RDA", k_pre, 7);
    chk(k_bank == 12, "R6", "bank_ok after RDA", k_bank, 12);

    // R7: early WR then early PRE; first code kept
    step(1, C_RD, 2, 0);
    step(1, C_WR, 2, 0);
    step(1, C_PRE, 2, 0);
    chk(s_viol == 1'b1 && s_code == C_WR, "R7", "first violation", int'({s_viol, s_code}), int'({1'b1, C_WR}));
    idle();
    chk(s_code == C_WR, "R7", "code retained", int'(s_code), int'(C_WR));
    // R8: sticky, then cleared
    step(0, C_NOP, 0, 1);
    chk(s_viol == 1'b1, "R8", "sticky before clear", int'(s_viol), 1);
    idle();
    chk(s_viol == 1'b0 && s_code == 3'd0, "R8", "cleared", int'({s_viol, s_code}), 0);

    // R2: codes 6 and 7 are ignored
    for (int k = 0; k < 12; k++) idle();
    step(1, 3'd7, 2, 0);
    step(1, 3'd6, 2, 0);
    idle();
    chk(s_viol == 1'b0, "R2", "code 6/7 viol", int'(s_viol), 0);
    chk(s_wr == 1'b1 && s_pre[2] == 1'b1 && s_bank[2] == 1'b1, "R2", "code 6/7 state",
        int'({s_wr, s_pre[2], s_bank[2]}), 7);

    // R8: illegal command together with clear wins
    step(1, C_RD, 4, 0);
    step(1, C_PRE, 4, 1);
    idle();
    chk(s_viol == 1'b1 && s_code == C_PRE, "R8", "set beats clear", int'({s_viol, s_code}), int'({1'b1, C_PRE}));
    step(0, C_NOP, 0, 1);

    rand_run(3000);

    // Config B: RL5 WL9 AL0 CCD4 RTP2 RP3 -> write gap 2, four-clock floor
    do_reset(5, 9, 0, 4, 2, 3);
    step(1, C_RD, 0, 0);
    k_wr = 0; k_pre = 0;
    for (int k = 1; k <= 12; k++) begin
      idle();
      if (s_wr && k_wr == 0) k_wr = k;
      if (s_pre[0] && k_pre == 0) k_pre = k;
    end
    chk(k_wr == 2, "R3", "short write gap", k_wr, 2);
    chk(k_pre == 4, "R4", "four-clock floor", k_pre, 4);

    // R9: change timing inputs without reset; windows must not move
    cfg_rl = 6'd20; cfg_wl = 6'd1; cfg_al = 6'd9; cfg_rtp = 6'd9; cfg_rp = 6'd30;
    step(1, C_RD, 6, 0);
    k_wr = 0; k_pre = 0;
    for (int k = 1; k <= 30; k++) begin
      idle();
      if (s_wr && k_wr == 0) k_wr = k;
      if (s_pre[6] && k_pre == 0) k_pre = k;
    end
    chk(k_wr == 2, "R9", "write gap after cfg change", k_wr, 2);
    chk(k_pre == 4, "R9", "pre gap after cfg change", k_pre, 4);
    step(1, C_PRE, 6, 0);
    k_bank = 0;
    for (int k = 1; k <= 40; k++) begin
      idle();
      if (s_bank[6] && k_bank == 0) k_bank = k;
    end
    chk(k_bank == 3, "R9", "tRP after cfg change", k_bank, 3);

    rand_run(2000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule